// File: doc/BRIEF.md
# Receive Byte Queue with Break Capture

This block sits behind a serial receiver and holds incoming bytes in a four-slot first-in first-out store until software reads them. The receiver offers a byte on a push strobe. The block accepts it only when the receive side is enabled and the store has room, and it reports that condition on a ready output. A register read raises the pop strobe and takes the oldest byte from the head output in the same access. The store then advances at the next clock edge.

Two status flags follow the store: one says data is waiting and one says the store is full. A line break from the receiver stores a zero byte, even when the store is full. It also raises a sticky break flag that stays set until a dedicated clear input is asserted. A flush input, driven by the receiver-reset command, empties the store in a single cycle.

Top module: `rx_byte_queue`

## Requirements
- R1: The store holds exactly four bytes. `full_flag` is high exactly when four bytes are stored, and it falls after any pop that lowers the count below four.
- R2: `rdy_flag` is high whenever at least one byte is stored. Every accepted push or break raises it. It falls only after a pop that empties the store, or after a flush.
- R3: Bytes leave in arrival order. `pop_byte` shows the oldest stored byte combinationally while the store is non-empty, and a pop removes that byte at the next rising clock edge.
- R4: A pop while the store is empty presents 0x00 on `pop_byte` and changes no state.
- R5: `push_rdy` equals `rx_en` and not `full_flag`. A `push_vld` raised while `push_rdy` is low is ignored.
- R6: A write that arrives while four bytes remain after any pop in the same cycle replaces the newest stored byte. The count stays at four.
- R7: `brk_in` stores a 0x00 byte whatever the state of `rx_en` and `full_flag`, using the rule in R6 when the store is full. A `push_vld` in the same cycle is ignored.
- R8: `brk_in` sets `brk_flag` at the next edge. The flag stays high until `brk_clr` is asserted. When both inputs are high in the same cycle, the set wins.
- R9: `flush` empties the store and clears `rdy_flag` and `full_flag` at the next edge. It overrides any push, break byte or pop in the same cycle, but it does not block a break from setting `brk_flag`.
- R10: A push or break together with a pop on a non-empty store delivers the oldest byte, stores the new byte, and leaves the count unchanged.
- R11: After reset the store is empty, `rdy_flag`, `full_flag` and `brk_flag` are low, and `pop_byte` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable |
| push_vld | input | 1 | Receiver offers a byte |
| push_byte | input | 8 | Offered byte |
| push_rdy | output | 1 | Receiver may push |
| brk_in | input | 1 | Break seen on the line (one cycle per event) |
| brk_clr | input | 1 | Clears the sticky break flag |
| pop | input | 1 | Register read of the data port |
| pop_byte | output | 8 | Oldest stored byte, or 0x00 when empty |
| flush | input | 1 | Receiver reset: empty the store |
| rdy_flag | output | 1 | At least one byte waiting |
| full_flag | output | 1 | Four bytes stored |
| brk_flag | output | 1 | Sticky break indication |

## Verification
The properties assume a well-behaved receiver. It raises `push_vld` only as a single-cycle strobe that it does not hold against a low `push_rdy`, and it raises `brk_in` for one cycle per event. Software is assumed to issue `pop` only as a read strobe. Several properties exclude the flush cycle explicitly, because `flush` may coincide with any other input. The stimulus keeps every input steady from one falling edge to the next. Besides directed sequences, it includes a random phase in which pushes against a full or disabled store, breaks at full, and flushes combined with pops all occur.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef struct packed {
    logic shift;  // advance every slot one step toward the head
    logic wr;     // write a byte into a slot
    logic zero;   // written byte is the break code 0x00
  } rxq_op_t;
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             push_vld,
  input  logic             brk_in,
  input  logic             pop,
  input  logic             flush,
  output rxq_op_t          op,
  output logic [IDX_W-1:0] wr_idx,
  output logic             head_vld,
  output logic             full,
  output logic             push_rdy
);
  logic [CNT_W-1:0] cnt_q, cnt_nx, cnt_mid;
  logic             take_pop, push_ok, cnt_en;

  assign full     = (cnt_q == CNT_W'(DEPTH));
  assign head_vld = (cnt_q != '0);
  assign push_rdy = rx_en & ~full;
  assign push_ok  = push_vld & push_rdy;
  assign take_pop = pop & head_vld & ~flush;

  // Slot arithmetic is done on the count left after this cycle's pop.
  always_comb begin
    cnt_mid  = cnt_q - CNT_W'(take_pop);
    op.shift = take_pop;
    op.wr    = (brk_in | push_ok) & ~flush;
    op.zero  = brk_in;
    wr_idx   = '0;
    cnt_nx   = cnt_mid;
    if (op.wr) begin
      if (cnt_mid == CNT_W'(DEPTH)) begin
        wr_idx = IDX_W'(DEPTH - 1);
        cnt_nx = cnt_mid;
      end else begin
        wr_idx = cnt_mid[IDX_W-1:0];
        cnt_nx = cnt_mid + 1'b1;
      end
    end
    if (flush) cnt_nx = '0;
  end

  assign cnt_en = flush | op.wr | take_pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nx;
  end
endmodule

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int DATA_W = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rxq_op_t           op,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] din,
  input  logic              head_vld,
  output logic [DATA_W-1:0] head
);
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] slot [DEPTH];

  assign wdata = op.zero ? '0 : din;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [DATA_W-1:0] slot_q, slot_nx, from_up;
    logic              hit, en;

    if (i == DEPTH - 1) begin : g_top
      assign from_up = slot_q;
    end else begin : g_mid
      assign from_up = slot[i+1];
    end

    assign hit = op.wr & (wr_idx == IDX_W'(i));
    assign en  = op.shift | hit;

    always_comb begin
      slot_nx = op.shift ? from_up : slot_q;
      if (hit) slot_nx = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  slot_q <= '0;
      else if (en) slot_q <= slot_nx;
    end

    assign slot[i] = slot_q;
  end

  assign head = head_vld ? slot[0] : '0;
endmodule

// File: rtl/rxq_break.sv
module rxq_break (
  input  logic clk,
  input  logic rst_n,
  input  logic brk_in,
  input  logic brk_clr,
  output logic brk_flag
);
  logic flag_q, flag_nx, flag_en;

  assign flag_en = brk_in | brk_clr;

  always_comb begin
    flag_nx = flag_q;
    if (brk_clr) flag_nx = 1'b0;
    if (brk_in)  flag_nx = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_nx;
  end

  assign brk_flag = flag_q;
endmodule

// File: rtl/rx_byte_queue.sv
module rx_byte_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int DATA_W = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              push_vld,
  input  logic [DATA_W-1:0] push_byte,
  output logic              push_rdy,
  input  logic              brk_in,
  input  logic              brk_clr,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_byte,
  input  logic              flush,
  output logic              rdy_flag,
  output logic              full_flag,
  output logic              brk_flag
);
  rxq_op_t          op;
  logic [IDX_W-1:0] wr_idx;
  logic             head_vld, full;

  rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .push_vld(push_vld),
    .brk_in(brk_in), .pop(pop), .flush(flush), .op(op), .wr_idx(wr_idx),
    .head_vld(head_vld), .full(full), .push_rdy(push_rdy)
  );

  rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .op(op), .wr_idx(wr_idx), .din(push_byte),
    .head_vld(head_vld), .head(pop_byte)
  );

  rxq_break u_brk (
    .clk(clk), .rst_n(rst_n), .brk_in(brk_in), .brk_clr(brk_clr),
    .brk_flag(brk_flag)
  );

  assign rdy_flag  = head_vld;
  assign full_flag = full;
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_en,
  input logic       push_vld,
  input logic [7:0] push_byte,
  input logic       push_rdy,
  input logic       brk_in,
  input logic       brk_clr,
  input logic       pop,
  input logic [7:0] pop_byte,
  input logic       flush,
  input logic       rdy_flag,
  input logic       full_flag,
  input logic       brk_flag
);
  AST_FULL_IMPLIES_READY: assert property (@(posedge clk) disable iff (!rst_n)
    full_flag |-> rdy_flag); // R1
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (full_flag && !pop && !flush) |=> full_flag); // R1
  AST_PUSH_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (push_vld && push_rdy && !flush) |=> rdy_flag); // R2
  AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_flag |-> (pop_byte == 8'h00)); // R4
  AST_EMPTY_POP_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdy_flag && pop && !push_vld && !brk_in) |=> !rdy_flag); // R4
  AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    full_flag |-> !push_rdy); // R5
  AST_BREAK_STORES: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_in && !flush) |=> (rdy_flag && brk_flag)); // R7
  AST_BREAK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_flag && !brk_clr) |=> brk_flag); // R8
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!rdy_flag && !full_flag)); // R9
  AST_SWAP_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (full_flag && pop && brk_in && !flush) |=> full_flag); // R10
endmodule

bind rx_byte_queue rxq_checker u_chk (.*);

// File: tb/rx_byte_queue_test.sv
`timescale 1ns/1ps
module rx_byte_queue_test;
  logic       clk, rst_n;
  logic       rx_en, push_vld, brk_in, brk_clr, pop, flush;
  logic [7:0] push_byte;
  logic       push_rdy, rdy_flag, full_flag, brk_flag;
  logic [7:0] pop_byte;

  int errors = 0;
  int checks = 0;

  logic [7:0] mq[$];
  bit         mbrk;

  rx_byte_queue uut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .push_vld(push_vld),
    .push_byte(push_byte), .push_rdy(push_rdy), .brk_in(brk_in),
    .brk_clr(brk_clr), .pop(pop), .pop_byte(pop_byte), .flush(flush),
    .rdy_flag(rdy_flag), .full_flag(full_flag), .brk_flag(brk_flag)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s (%s): actual=%0h expected=%0h", req, tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    logic [7:0] eb;
    eb = (mq.size() > 0) ? mq[0] : 8'h00;
    chk("R3/R4 pop_byte", tag, pop_byte, eb);
    chk("R2 rdy_flag", tag, rdy_flag, mq.size() > 0);
    chk("R1 full_flag", tag, full_flag, mq.size() == 4);
    chk("R5 push_rdy", tag, push_rdy, rx_en && mq.size() != 4);
    chk("R8 brk_flag", tag, brk_flag, mbrk);
  endtask

  // Drive at the falling edge, compare before the rising edge, update model at it.
  task automatic step(input string tag, input bit en, input bit pv, input logic [7:0] pb,
                      input bit brk, input bit pp, input bit fl, input bit clr);
    bit was_full;
    rx_en = en; push_vld = pv; push_byte = pb; brk_in = brk;
    pop = pp; flush = fl; brk_clr = clr;
    #1;
    compare(tag);
    @(posedge clk);
    was_full = (mq.size() == 4);
    if (fl) mq.delete();
    else begin
      if (pp && mq.size() > 0) void'(mq.pop_front());
      if (brk) begin
        if (mq.size() == 4) mq[3] = 8'h00; else mq.push_back(8'h00);
      end else if (pv && en && !was_full) begin
        if (mq.size() == 4) mq[3] = pb; else mq.push_back(pb);
      end
    end
    if (brk) mbrk = 1'b1; else if (clr) mbrk = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx_en = 0; push_vld = 0; push_byte = 0; brk_in = 0;
    brk_clr = 0; pop = 0; flush = 0; mbrk = 0;
    repeat (3) @(negedge clk);
    compare("R11 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R11 after reset");

    step("R5 push while disabled", 0, 1, 8'h55, 0, 0, 0, 0);
    step("R4 pop on empty", 1, 0, 8'h00, 0, 1, 0, 0);
    step("R2 push A1", 1, 1, 8'hA1, 0, 0, 0, 0);
    step("R3 push B2", 1, 1, 8'hB2, 0, 0, 0, 0);
    step("R3 push C3", 1, 1, 8'hC3, 0, 0, 0, 0);
    step("R10 push D4 with pop", 1, 1, 8'hD4, 0, 1, 0, 0);
    step("R1 push E5 to full", 1, 1, 8'hE5, 0, 0, 0, 0);
    step("R1 push F6 fill", 1, 1, 8'hF6, 0, 0, 0, 0);
    step("R5 push while full ignored", 1, 1, 8'h77, 0, 0, 0, 0);
    step("R6 R7 break at full overwrites newest", 1, 0, 8'h00, 1, 0, 0, 0);
    step("R10 break with pop at full", 1, 0, 8'h00, 1, 1, 0, 0);
    step("R8 flag sticky", 1, 0, 8'h00, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) step("R3 drain", 1, 0, 8'h00, 0, 1, 0, 0);
    step("R8 clear", 1, 0, 8'h00, 0, 0, 0, 1);
    step("R7 break while disabled", 0, 1, 8'h99, 1, 0, 0, 0);
    step("R8 set and clear together", 0, 0, 8'h00, 1, 0, 0, 1);
    step("R2 push", 1, 1, 8'h3C, 0, 0, 0, 1);
    step("R9 flush with push and pop", 1, 1, 8'h4D, 0, 1, 1, 0);
    step("R9 after flush", 1, 1, 8'h5E, 0, 0, 0, 0);
    step("R9 flush with break", 1, 0, 8'h00, 1, 0, 1, 0);
    step("R9 check", 1, 0, 8'h00, 0, 0, 0, 0);

    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom_range(0, 99);
      step("R6 R10 random", r < 90, $urandom_range(0, 99) < 60, 8'($urandom),
           $urandom_range(0, 99) < 8, $urandom_range(0, 99) < 35,
           $urandom_range(0, 99) < 4, $urandom_range(0, 99) < 10);
    end
    step("final", 0, 0, 8'h00, 0, 0, 0, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule